// File: doc/BRIEF.md
# Decode Slot Steering with Compare/Branch Fusion

This block sits between an instruction fetch queue and a bank of four decoders. Each cycle the queue presents a window of up to five pre-decoded entries. Every entry carries a valid bit, its micro-op count and a class tag that marks it as a compare, a conditional branch or something else. The block walks the window in program order and places each entry into one of four decode slots. Three of the slots take only single-micro-op entries. The fourth slot, the complex slot, takes any entry of up to four micro-ops. A compare that is directly followed by a conditional branch inside the same window is merged into one fused entry, and that entry occupies a single slot. One fused pair therefore lets the four slots take five instructions in one cycle.

The block reports how many window entries it took, so the queue can advance by that amount. When the oldest entry needs more micro-ops than the complex slot allows, the block hands that entry to a microcode sequencer instead. It then stops taking instructions until the sequencer signals completion. All outputs are registered.

A small state machine controls the behaviour. In `ST_STEER` the window is steered every cycle. The transition *ucode_handoff* (`ST_STEER` to `ST_UCODE_WAIT`) is taken when the oldest entry is too long for any slot. In `ST_UCODE_WAIT` intake is frozen. The transition *ucode_release* (`ST_UCODE_WAIT` to `ST_STEER`) is taken on the first cycle `ucode_done_i` is high. Reset enters `ST_STEER`.

Top module: `dec_steer_top`

## Requirements
- R1: While `rst_ni` is low and after reset, with no valid window entries, all `slot_valid_o` bits are 0, `consumed_o` is 0 and `ucode_req_o` is 0.
- R2: Entries with a micro-op count of 0 or 1 fill the simple slots 0, 1 and 2 in program order. `slot_src_o` gives the window position of each entry (3 bits per slot, slot k at bits 3k+2..3k). A fourth such entry goes to slot 3, the complex slot, if that slot is free.
- R3: An entry of 2 to 4 micro-ops can only be placed in slot 3. Only one entry is placed there per cycle, so a second multi-micro-op entry ends the group.
- R4: Steering is strictly in program order. The first entry that cannot be placed, or the first invalid entry, ends the group. No later entry is placed in that cycle, and `consumed_o` counts only the entries before it.
- R5: When the entry at position i has class 1 (compare), the entry at i+1 has class 2 (conditional branch), both are valid and both have one micro-op, the two are fused. They take one slot with `slot_fused_o` set and `slot_src_o` equal to i, and they add 2 to `consumed_o`. Class 0 means any other instruction.
- R6: `consumed_o` equals the number of occupied slots plus the number of fused slots. It reaches 5 when four slots hold one fused pair, and it never exceeds 5.
- R7: A compare in the last window position (4) is never fused. It is placed as an ordinary single entry.
- R8: An entry of more than 4 micro-ops at position 0 raises `ucode_req_o` with `consumed_o` = 1 and no slots occupied. At a later position, such an entry only ends the group and raises no request.
- R9: While `ucode_req_o` is high, later cycles show no occupied slots and `consumed_o` = 0, whatever the window holds. The cycle after `ucode_done_i` is sampled high, `ucode_req_o` is 0, and steering resumes on the following edge. `ucode_done_i` has no effect while no request is pending.
- R10: Each result appears at the outputs after the rising clock edge at which the window was sampled, and stays there until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| win_valid_i | input | WIN (5) | Valid bit per window position, position 0 oldest |
| win_uops_i | input | WIN*UOP_W (15) | Micro-op count per position, 3 bits each |
| win_class_i | input | WIN*2 (10) | Class per position: 0 other, 1 compare, 2 conditional branch |
| ucode_done_i | input | 1 | Microcode sequencer finished the handed-off entry |
| slot_valid_o | output | NSLOT (4) | Slot occupied; slots 0..2 simple, slot 3 complex |
| slot_src_o | output | NSLOT*IDX_W (12) | Window position placed in each slot |
| slot_fused_o | output | NSLOT (4) | Slot holds a fused compare/branch pair |
| consumed_o | output | CNT_W (3) | Number of window entries taken, 0..5 |
| ucode_req_o | output | 1 | Request to the microcode sequencer |

## Verification
Every steering result is due exactly one rising edge after the window is applied. The bench drives each window on a falling edge and samples the outputs on the next falling edge. This places every check half a cycle after the single register stage, before the next window can be sampled. The microcode handshake adds one edge for the hand-off and one edge for the release. The bench therefore steps the wait state one cycle at a time and checks the request, the empty slots and the zero count on each cycle. It then checks that steering resumes exactly one cycle after the release.

// File: rtl/dec_steer_pkg.sv
package dec_steer_pkg;

    // Class tag carried by each pre-decoded window entry.
    typedef enum logic [1:0] {
        CLS_OTHER = 2'd0,
        CLS_CMP   = 2'd1,
        CLS_JCC   = 2'd2,
        CLS_RSVD  = 2'd3
    } insn_class_e;

    // Intake control states.
    typedef enum logic {
        ST_STEER      = 1'b0,
        ST_UCODE_WAIT = 1'b1
    } steer_state_e;

endpackage

// File: rtl/dec_fuse_detect.sv
module dec_fuse_detect
    import dec_steer_pkg::*;
#(
    parameter int WIN   = 5,
    parameter int UOP_W = 3
) (
    input  logic [WIN-1:0]       win_valid_i,
    input  logic [WIN*UOP_W-1:0] win_uops_i,
    input  logic [WIN*2-1:0]     win_class_i,
    output logic [WIN-1:0]       fuse_ok_o
);

    // A position can start a fused pair only when its partner is inside the window.
    for (genvar i = 0; i < WIN; i++) begin : g_pos
        if (i < WIN - 1) begin : g_pair
            logic head_ok;
            logic tail_ok;
            assign head_ok = win_valid_i[i]
                           && (win_class_i[2*i +: 2] == CLS_CMP)
                           && (win_uops_i[i*UOP_W +: UOP_W] == UOP_W'(1));
            assign tail_ok = win_valid_i[i+1]
                           && (win_class_i[2*(i+1) +: 2] == CLS_JCC)
                           && (win_uops_i[(i+1)*UOP_W +: UOP_W] == UOP_W'(1));
            assign fuse_ok_o[i] = head_ok && tail_ok;
        end else begin : g_last
            assign fuse_ok_o[i] = 1'b0;
        end
    end

endmodule

// File: rtl/dec_slot_alloc.sv
module dec_slot_alloc #(
    parameter int WIN      = 5,
    parameter int NSIMPLE  = 3,
    parameter int CPLX_MAX = 4,
    parameter int UOP_W    = 3,
    localparam int NSLOT   = NSIMPLE + 1,
    localparam int IDX_W   = $clog2(WIN),
    localparam int CNT_W   = $clog2(WIN + 1),
    localparam int SLOT_W  = $clog2(NSLOT)
) (
    input  logic [WIN-1:0]         win_valid_i,
    input  logic [WIN*UOP_W-1:0]   win_uops_i,
    input  logic [WIN-1:0]         fuse_ok_i,
    output logic [NSLOT-1:0]       slot_valid_o,
    output logic [NSLOT*IDX_W-1:0] slot_src_o,
    output logic [NSLOT-1:0]       slot_fused_o,
    output logic [CNT_W-1:0]       consumed_o,
    output logic                   ucode_o
);

    // In-order walk: each position either lands in a slot, ends the group,
    // or is skipped because it is the branch half of a fused pair.
    always_comb begin : walk
        logic [SLOT_W-1:0] nsimp;
        logic [SLOT_W-1:0] tgt;
        logic [CNT_W-1:0]  cnt;
        logic              place;
        logic              stop;
        logic              skip;
        logic              cplx_used;
        logic              single;
        logic [UOP_W-1:0]  uops;

        slot_valid_o = '0;
        slot_src_o   = '0;
        slot_fused_o = '0;
        ucode_o      = 1'b0;
        nsimp        = '0;
        tgt          = '0;
        cnt          = '0;
        place        = 1'b0;
        stop         = 1'b0;
        skip         = 1'b0;
        cplx_used    = 1'b0;
        single       = 1'b0;
        uops         = '0;

        for (int i = 0; i < WIN; i++) begin
            place = 1'b0;
            if (skip) begin
                skip = 1'b0;
            end else if (!stop) begin
                uops   = win_uops_i[i*UOP_W +: UOP_W];
                single = (uops <= UOP_W'(1));
                if (!win_valid_i[i]) begin
                    stop = 1'b1;
                end else if (uops > UOP_W'(CPLX_MAX)) begin
                    if (i == 0) begin
                        ucode_o = 1'b1;
                        cnt     = CNT_W'(1);
                    end
                    stop = 1'b1;
                end else if (single && (nsimp < SLOT_W'(NSIMPLE))) begin
                    tgt   = nsimp;
                    nsimp = nsimp + SLOT_W'(1);
                    place = 1'b1;
                end else if (!cplx_used) begin
                    tgt       = SLOT_W'(NSIMPLE);
                    cplx_used = 1'b1;
                    place     = 1'b1;
                end else begin
                    stop = 1'b1;
                end

                if (place) begin
                    slot_valid_o[tgt]                = 1'b1;
                    slot_src_o[tgt*IDX_W +: IDX_W]   = IDX_W'(i);
                    slot_fused_o[tgt]                = fuse_ok_i[i];
                    cnt  = cnt + (fuse_ok_i[i] ? CNT_W'(2) : CNT_W'(1));
                    skip = fuse_ok_i[i];
                end
            end
        end

        consumed_o = cnt;
    end

endmodule

// File: rtl/dec_steer_top.sv
module dec_steer_top
    import dec_steer_pkg::*;
#(
    parameter int WIN      = 5,
    parameter int NSIMPLE  = 3,
    parameter int CPLX_MAX = 4,
    parameter int UOP_W    = 3,
    localparam int NSLOT   = NSIMPLE + 1,
    localparam int IDX_W   = $clog2(WIN),
    localparam int CNT_W   = $clog2(WIN + 1)
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [WIN-1:0]         win_valid_i,
    input  logic [WIN*UOP_W-1:0]   win_uops_i,
    input  logic [WIN*2-1:0]       win_class_i,
    input  logic                   ucode_done_i,
    output logic [NSLOT-1:0]       slot_valid_o,
    output logic [NSLOT*IDX_W-1:0] slot_src_o,
    output logic [NSLOT-1:0]       slot_fused_o,
    output logic [CNT_W-1:0]       consumed_o,
    output logic                   ucode_req_o
);

    logic [WIN-1:0]         fuse_ok;
    logic [NSLOT-1:0]       alloc_valid;
    logic [NSLOT*IDX_W-1:0] alloc_src;
    logic [NSLOT-1:0]       alloc_fused;
    logic [CNT_W-1:0]       alloc_cnt;
    logic                   alloc_ucode;

    steer_state_e state_q;
    steer_state_e state_d;

    dec_fuse_detect #(
        .WIN   (WIN),
        .UOP_W (UOP_W)
    ) u_fuse (
        .win_valid_i (win_valid_i),
        .win_uops_i  (win_uops_i),
        .win_class_i (win_class_i),
        .fuse_ok_o   (fuse_ok)
    );

    dec_slot_alloc #(
        .WIN      (WIN),
        .NSIMPLE  (NSIMPLE),
        .CPLX_MAX (CPLX_MAX),
        .UOP_W    (UOP_W)
    ) u_alloc (
        .win_valid_i  (win_valid_i),
        .win_uops_i   (win_uops_i),
        .fuse_ok_i    (fuse_ok),
        .slot_valid_o (alloc_valid),
        .slot_src_o   (alloc_src),
        .slot_fused_o (alloc_fused),
        .consumed_o   (alloc_cnt),
        .ucode_o      (alloc_ucode)
    );

    // Next-state logic: ucode_handoff and ucode_release.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STEER:      state_d = alloc_ucode  ? ST_UCODE_WAIT : ST_STEER;
            ST_UCODE_WAIT: state_d = ucode_done_i ? ST_STEER      : ST_UCODE_WAIT;
            default:       state_d = ST_STEER;
        endcase
    end

    // State register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_STEER;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            slot_valid_o <= '0;
            slot_src_o   <= '0;
            slot_fused_o <= '0;
            consumed_o   <= '0;
            ucode_req_o  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_STEER: begin
                    slot_valid_o <= alloc_valid;
                    slot_src_o   <= alloc_src;
                    slot_fused_o <= alloc_fused;
                    consumed_o   <= alloc_cnt;
                    ucode_req_o  <= alloc_ucode;
                end
                ST_UCODE_WAIT: begin
                    slot_valid_o <= '0;
                    slot_src_o   <= '0;
                    slot_fused_o <= '0;
                    consumed_o   <= '0;
                    ucode_req_o  <= !ucode_done_i;
                end
                default: begin
                    slot_valid_o <= '0;
                    slot_src_o   <= '0;
                    slot_fused_o <= '0;
                    consumed_o   <= '0;
                    ucode_req_o  <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/dec_steer_checker.sv
module dec_steer_checker #(
    parameter int WIN      = 5,
    parameter int NSIMPLE  = 3,
    parameter int UOP_W    = 3,
    localparam int NSLOT   = NSIMPLE + 1,
    localparam int IDX_W   = $clog2(WIN),
    localparam int CNT_W   = $clog2(WIN + 1)
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic                   ucode_done_i,
    input logic [NSLOT-1:0]       slot_valid_o,
    input logic [NSLOT*IDX_W-1:0] slot_src_o,
    input logic [NSLOT-1:0]       slot_fused_o,
    input logic [CNT_W-1:0]       consumed_o,
    input logic                   ucode_req_o
);

    // R9: a pending request keeps the slots empty after the hand-off cycle.
    assert_req_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ucode_req_o && $past(ucode_req_o)) |-> (slot_valid_o == '0 && consumed_o == '0));

    // R9: the request only drops after the done signal was seen.
    assert_req_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(ucode_req_o) |-> $past(ucode_done_i));

    // R8: the hand-off cycle takes exactly one entry and fills no slot.
    assert_handoff_one_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ucode_req_o) |-> (consumed_o == CNT_W'(1) && slot_valid_o == '0));

    // R6: consumed count matches occupied plus fused slots, and stays within the window.
    assert_count_match_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ucode_req_o |-> (int'(consumed_o) == $countones(slot_valid_o) + $countones(slot_fused_o)));

    assert_count_max_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(consumed_o) <= WIN);

    // R5: a fused marker only appears on an occupied slot.
    assert_fused_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slot_fused_o & ~slot_valid_o) == '0);

    // R2: simple slots fill from slot 0 upward without holes.
    for (genvar k = 0; k < NSIMPLE - 1; k++) begin : g_prefix
        assert_simple_prefix_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            slot_valid_o[k+1] |-> slot_valid_o[k]);
    end

endmodule

bind dec_steer_top dec_steer_checker #(
    .WIN     (WIN),
    .NSIMPLE (NSIMPLE),
    .UOP_W   (UOP_W)
) u_checker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ucode_done_i (ucode_done_i),
    .slot_valid_o (slot_valid_o),
    .slot_src_o   (slot_src_o),
    .slot_fused_o (slot_fused_o),
    .consumed_o   (consumed_o),
    .ucode_req_o  (ucode_req_o)
);

// File: tb/dec_steer_top_test.sv
`timescale 1ns/1ps
module dec_steer_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  win_valid = '0;
    logic [14:0] win_uops = '0;
    logic [9:0]  win_class = '0;
    logic        ucode_done = 1'b0;
    logic [3:0]  slot_valid;
    logic [11:0] slot_src;
    logic [3:0]  slot_fused;
    logic [2:0]  consumed;
    logic        ucode_req;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dec_steer_top uut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .win_valid_i  (win_valid),
        .win_uops_i   (win_uops),
        .win_class_i  (win_class),
        .ucode_done_i (ucode_done),
        .slot_valid_o (slot_valid),
        .slot_src_o   (slot_src),
        .slot_fused_o (slot_fused),
        .consumed_o   (consumed),
        .ucode_req_o  (ucode_req)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_slot(input string req, input int k, input int v, input int src, input int f);
        chk(req, $sformatf("slot%0d valid", k), int'(slot_valid[k]), v);
        if (v != 0) begin
            chk(req, $sformatf("slot%0d src", k), int'(slot_src[k*3 +: 3]), src);
            chk(req, $sformatf("slot%0d fused", k), int'(slot_fused[k]), f);
        end
    endtask

    task automatic chk_out(input string req, input int vmask, input int cnt, input int req_exp);
        chk(req, "slot_valid", int'(slot_valid), vmask);
        chk(req, "consumed", int'(consumed), cnt);
        chk(req, "ucode_req", int'(ucode_req), req_exp);
    endtask

    // Drive a window at the current falling edge; return one falling edge later.
    task automatic step(input logic [4:0] v, input int u[5], input int c[5]);
        win_valid = v;
        for (int i = 0; i < 5; i++) begin
            win_uops[i*3 +: 3]  = 3'(u[i]);
            win_class[i*2 +: 2] = 2'(c[i]);
        end
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        @(negedge clk);
        chk_out("R1", 0, 0, 0);
        rst_n = 1'b1;
        step(5'b00000, '{1,1,1,1,1}, '{0,0,0,0,0});
        chk_out("R1", 0, 0, 0);
    endtask

    task automatic t_simple_fill();
        step(5'b11111, '{1,1,0,1,1}, '{0,0,0,0,0});
        chk_out("R2", 4'b1111, 4, 0);
        chk_slot("R2", 0, 1, 0, 0);
        chk_slot("R2", 1, 1, 1, 0);
        chk_slot("R2", 2, 1, 2, 0);
        chk_slot("R2", 3, 1, 3, 0);
    endtask

    task automatic t_complex_limit();
        step(5'b11111, '{1,3,1,2,1}, '{0,0,0,0,0});
        chk_out("R3", 4'b1011, 3, 0);
        chk_slot("R3", 0, 1, 0, 0);
        chk_slot("R3", 1, 1, 2, 0);
        chk_slot("R3", 3, 1, 1, 0);
    endtask

    task automatic t_in_order_stop();
        step(5'b11011, '{1,1,1,1,1}, '{0,0,0,0,0});
        chk_out("R4", 4'b0011, 2, 0);
        step(5'b11111, '{4,1,2,1,1}, '{0,0,0,0,0});
        chk_out("R4", 4'b1001, 2, 0);
        chk_slot("R4", 3, 1, 0, 0);
        chk_slot("R4", 0, 1, 1, 0);
    endtask

    task automatic t_fuse_one();
        step(5'b11111, '{1,1,1,1,1}, '{1,2,0,0,0});
        chk_out("R6", 4'b1111, 5, 0);
        chk_slot("R5", 0, 1, 0, 1);
        chk_slot("R5", 1, 1, 2, 0);
        chk_slot("R5", 2, 1, 3, 0);
        chk_slot("R5", 3, 1, 4, 0);
        step(5'b11111, '{1,2,1,1,1}, '{1,2,0,0,0});
        chk_out("R5", 4'b1111, 4, 0);
        chk_slot("R5", 0, 1, 0, 0);
        chk_slot("R5", 3, 1, 1, 0);
    endtask

    task automatic t_fuse_two();
        step(5'b11111, '{1,1,1,1,1}, '{1,2,1,2,0});
        chk_out("R6", 4'b0111, 5, 0);
        chk_slot("R6", 0, 1, 0, 1);
        chk_slot("R6", 1, 1, 2, 1);
        chk_slot("R6", 2, 1, 4, 0);
    endtask

    task automatic t_last_cmp();
        step(5'b11111, '{1,1,1,1,1}, '{1,2,0,0,1});
        chk_out("R7", 4'b1111, 5, 0);
        chk_slot("R7", 3, 1, 4, 0);
        step(5'b11111, '{1,1,1,1,1}, '{0,0,0,1,2});
        chk_out("R7", 4'b1111, 5, 0);
        chk_slot("R7", 3, 1, 3, 1);
    endtask

    task automatic t_ucode();
        step(5'b11111, '{1,1,6,1,1}, '{0,0,0,0,0});
        chk_out("R8", 4'b0011, 2, 0);
        step(5'b11111, '{6,1,1,1,1}, '{0,0,0,0,0});
        chk_out("R8", 0, 1, 1);
        for (int n = 0; n < 3; n++) begin
            step(5'b11111, '{1,1,1,1,1}, '{0,0,0,0,0});
            chk_out("R9", 0, 0, 1);
        end
        ucode_done = 1'b1;
        step(5'b11111, '{1,1,1,1,1}, '{0,0,0,0,0});
        chk_out("R9", 0, 0, 0);
        ucode_done = 1'b0;
        step(5'b11111, '{1,1,1,1,1}, '{0,0,0,0,0});
        chk_out("R9", 4'b1111, 4, 0);
        ucode_done = 1'b1;
        step(5'b11111, '{1,1,1,1,1}, '{1,2,0,0,0});
        chk_out("R9", 4'b1111, 5, 0);
        ucode_done = 1'b0;
    endtask

    task automatic t_registered();
        step(5'b00000, '{1,1,1,1,1}, '{0,0,0,0,0});
        win_valid = 5'b00111;
        @(posedge clk);
        #1;
        chk("R10", "consumed just after edge", int'(consumed), 3);
        win_valid = 5'b00001;
        #1;
        chk("R10", "consumed held between edges", int'(consumed), 3);
        @(negedge clk);
        chk("R10", "consumed after next edge", int'(consumed), 3);
        step(5'b00000, '{1,1,1,1,1}, '{0,0,0,0,0});
        chk_out("R10", 0, 0, 0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        t_reset();
        t_simple_fill();
        t_complex_limit();
        t_in_order_stop();
        t_fuse_one();
        t_fuse_two();
        t_last_cmp();
        t_ucode();
        t_registered();
        finished = 1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual running expected done");
            finish_run();
        end
    end

endmodule